// File: doc/BRIEF.md
# Multi-mode DDS Phase Generator

This block is a digital direct-synthesis core. Every clock cycle it adds a 48-bit tuning increment to a phase accumulator. It adds a 14-bit phase offset to the top of the accumulated phase and truncates the result to a 17-bit phase word. It turns that word into a 12-bit signed cosine sample and scales the sample by a 12-bit amplitude factor. It holds two tuning increments and two phase offsets. A 3-bit mode code decides whether a single select pin switches between the two increments, switches between the two offsets, or is ignored.

A host writes configuration fields into buffer registers through a simple write port. The writes have no effect until the host pulses an update strobe. The strobe is synchronised to the core clock. On the resulting internal update pulse, every buffered field is copied into the working registers on the same clock edge. A synchronous clear input forces the accumulator to zero, so a phase ramp can be started from a known point.

Top module: `dds_core`

## Requirements
- R1: After reset, phase_o and sample_o are 0, and all working registers are 0 (both increments, both offsets, amplitude and mode).
- R2: Writes change only buffer registers. Write addresses: 0 = increment A, 1 = increment B, 2 = offset A (low 14 bits of data), 3 = offset B (low 14 bits), 4 = amplitude (low 12 bits), 5 = mode (low 3 bits). No write changes the output until an update strobe. A one-cycle high pulse on upd_i makes the buffered values active within 5 cycles.
- R3: One update copies every buffered field into the working registers on the same clock edge. Between update pulses the working registers stay stable.
- R4: The accumulator is 48 bits wide and wraps modulo 2^48. On each clock edge with clr_i low it adds the selected increment. On each edge with clr_i high it becomes 0.
- R5: phase_o is registered one cycle after the accumulator. Its value is (acc[47:31] + offset*8) mod 2^17, where offset is the selected 14-bit offset.
- R6: Mode 3'b001 uses sel_i to choose the increment (0 = A, 1 = B) and always uses offset A. Mode 3'b100 uses sel_i to choose the offset (0 = A, 1 = B) and always uses increment A. Every other mode code (000, 010, 011, 101 to 111) uses increment A and offset A and ignores sel_i.
- R7: The cosine stage takes the top 7 bits b of the phase word and produces c = round(2047*cos(2*pi*(b+0.5)/128)), with at most 1 LSB error. It uses a 32-entry quarter-wave table with quadrant folding.
- R8: sample_o = floor(c*amp/4096), where amp is the active amplitude. sample_o appears exactly two cycles after the phase word it was computed from. An amplitude of 0 gives a sample of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous accumulator clear |
| sel_i | input | 1 | Register-pair select, used according to mode |
| wr_en_i | input | 1 | Buffer write enable |
| wr_addr_i | input | 3 | Buffer field address |
| wr_data_i | input | 48 | Buffer write data, low bits used for narrow fields |
| upd_i | input | 1 | Update strobe, asynchronous to the core clock |
| phase_o | output | 17 | Truncated phase word with offset applied |
| sample_o | output | 12 | Signed amplitude-scaled cosine sample |

## Verification
The assertions take three things for granted. The update strobe is a level that a two-flop synchroniser can capture. Reset holds for at least one clock edge. sel_i and clr_i are valid at every rising edge. The bench changes every input only on the falling edge. It holds upd_i high for one full cycle and then waits well past the synchroniser delay before checking, so no check depends on the cycle in which an update lands. sel_i and the mode stay fixed during each phase ramp and each cosine sweep, so each expected value has a single source.

// File: rtl/dds_pkg.sv
// Package dds_pkg
// Shared mode codes and host-side field addresses for the DDS phase generator.
// Assumes a 3-bit mode field and a 3-bit field address.
package dds_pkg;
    typedef enum logic [2:0] {
        MD_TONE  = 3'b000,
        MD_FSK   = 3'b001,
        MD_RAMPF = 3'b010,
        MD_SWEEP = 3'b011,
        MD_BPSK  = 3'b100
    } dds_mode_e;

    localparam logic [2:0] FLD_INC_A = 3'd0;
    localparam logic [2:0] FLD_INC_B = 3'd1;
    localparam logic [2:0] FLD_OFS_A = 3'd2;
    localparam logic [2:0] FLD_OFS_B = 3'd3;
    localparam logic [2:0] FLD_AMP   = 3'd4;
    localparam logic [2:0] FLD_MODE  = 3'd5;
endpackage

// File: rtl/dds_cfg_bank.sv
// Module dds_cfg_bank
// Holds the host-written buffer registers and the working registers. An
// update strobe passes through SYNC_N flops. Its rising edge then copies
// every buffered field into the working set on one clock edge.
// Assumes FTW_W >= POW_W and FTW_W >= AMP_W.
module dds_cfg_bank #(
    parameter int FTW_W  = 48,
    parameter int POW_W  = 14,
    parameter int AMP_W  = 12,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [FTW_W-1:0] wr_data_i,
    input  logic             upd_i,
    output logic [FTW_W-1:0] inc_a_o,
    output logic [FTW_W-1:0] inc_b_o,
    output logic [POW_W-1:0] ofs_a_o,
    output logic [POW_W-1:0] ofs_b_o,
    output logic [AMP_W-1:0] amp_o,
    output logic [2:0]       mode_o,
    output logic             upd_pulse_o
);
    import dds_pkg::*;

    logic [FTW_W-1:0] inc_a_b, inc_b_b;
    logic [POW_W-1:0] ofs_a_b, ofs_b_b;
    logic [AMP_W-1:0] amp_b;
    logic [2:0]       mode_b;
    logic [SYNC_N:0]  sync_q;

    // Synchronise the strobe and keep one extra stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_N-1:0], upd_i};
    end

    assign upd_pulse_o = sync_q[SYNC_N-1] & ~sync_q[SYNC_N];

    // Host writes land in the buffer set only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_a_b <= '0;
            inc_b_b <= '0;
            ofs_a_b <= '0;
            ofs_b_b <= '0;
            amp_b   <= '0;
            mode_b  <= '0;
        end else if (wr_en_i) begin
            case (wr_addr_i)
                FLD_INC_A: inc_a_b <= wr_data_i;
                FLD_INC_B: inc_b_b <= wr_data_i;
                FLD_OFS_A: ofs_a_b <= wr_data_i[POW_W-1:0];
                FLD_OFS_B: ofs_b_b <= wr_data_i[POW_W-1:0];
                FLD_AMP:   amp_b   <= wr_data_i[AMP_W-1:0];
                FLD_MODE:  mode_b  <= wr_data_i[2:0];
                default:   ;
            endcase
        end
    end

    // Copy all buffered fields into the working set together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_a_o <= '0;
            inc_b_o <= '0;
            ofs_a_o <= '0;
            ofs_b_o <= '0;
            amp_o   <= '0;
            mode_o  <= '0;
        end else if (upd_pulse_o) begin
            inc_a_o <= inc_a_b;
            inc_b_o <= inc_b_b;
            ofs_a_o <= ofs_a_b;
            ofs_b_o <= ofs_b_b;
            amp_o   <= amp_b;
            mode_o  <= mode_b;
        end
    end
endmodule

// File: rtl/dds_phase_path.sv
// Module dds_phase_path
// Phase accumulator and phase word stage. The accumulator wraps modulo
// 2^FTW_W and clears synchronously. The phase word is the top PH_W bits
// of the accumulator plus the offset, aligned to the phase word's MSB.
// Assumes PH_W >= POW_W and FTW_W >= PH_W.
module dds_phase_path #(
    parameter int FTW_W = 48,
    parameter int POW_W = 14,
    parameter int PH_W  = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic [FTW_W-1:0] inc_i,
    input  logic [POW_W-1:0] ofs_i,
    output logic [FTW_W-1:0] acc_o,
    output logic [PH_W-1:0]  phase_o
);
    localparam int OFS_SH = PH_W - POW_W;

    // Accumulate the increment, or return to zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_o <= '0;
        else if (clr_i) acc_o <= '0;
        else            acc_o <= acc_o + inc_i;
    end

    // Truncate the accumulator and apply the phase offset.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_o <= '0;
        else        phase_o <= acc_o[FTW_W-1 -: PH_W] + (PH_W'(ofs_i) << OFS_SH);
    end
endmodule

// File: rtl/dds_cos_lut.sv
// Module dds_cos_lut
// Phase-to-amplitude stage. A quarter-wave table of 2^LUT_AW entries holds
// cosine values at bin midpoints. The table is computed at elaboration by
// an integer Taylor series. Quadrant folding mirrors and negates it into a
// full period. The output is registered.
// Assumes PH_W >= LUT_AW + 2.
module dds_cos_lut #(
    parameter int PH_W   = 17,
    parameter int LUT_AW = 5,
    parameter int AMP_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PH_W-1:0]         phase_i,
    output logic signed [AMP_W-1:0] cos_o
);
    localparam int     QN   = 1 << LUT_AW;
    localparam longint FS   = (longint'(1) <<< (AMP_W - 1)) - 1;
    localparam longint PI28 = 64'sd843314857;

    // Cosine of the centre of quarter-wave bin idx, in Q28, scaled to full-scale.
    function automatic logic [AMP_W-1:0] quarter_val(input int idx);
        longint x, x2, t, s;
        x  = (longint'(2 * idx + 1) * PI28) / longint'(4 * QN);
        x2 = (x * x) >>> 28;
        t  = longint'(1) <<< 28;
        s  = t;
        for (int k = 1; k <= 6; k++) begin
            t = -((t * x2) >>> 28) / longint'((2 * k - 1) * (2 * k));
            s = s + t;
        end
        return AMP_W'((s * FS + (longint'(1) <<< 27)) >>> 28);
    endfunction

    logic [AMP_W-1:0] qtab [QN];

    for (genvar gi = 0; gi < QN; gi++) begin : g_tab
        localparam logic [AMP_W-1:0] QV = quarter_val(gi);
        assign qtab[gi] = QV;
    end

    logic [1:0]        quad;
    logic [LUT_AW-1:0] idx;
    logic [AMP_W-1:0]  mag;
    logic              neg;

    // Fold the phase into the first quadrant and choose the sign.
    always_comb begin
        quad = phase_i[PH_W-1 -: 2];
        idx  = phase_i[PH_W-3 -: LUT_AW];
        mag  = quad[0] ? qtab[~idx] : qtab[idx];
        neg  = quad[1] ^ quad[0];
    end

    // Register the signed sample.
    always_ff @(posedge clk) begin
        if (!rst_n) cos_o <= '0;
        else        cos_o <= neg ? -$signed(mag) : $signed(mag);
    end
endmodule

// File: rtl/dds_core.sv
// Module dds_core
// Top of the multi-mode DDS phase generator. It joins the configuration
// bank, the mode-driven register selection, the phase path, the cosine
// table and the amplitude scaler. Latency: phase_o one cycle after the
// accumulator; sample_o two cycles after phase_o.
// Assumes sel_i and clr_i are synchronous to clk.
module dds_core #(
    parameter int FTW_W  = 48,
    parameter int POW_W  = 14,
    parameter int PH_W   = 17,
    parameter int AMP_W  = 12,
    parameter int LUT_AW = 5,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             sel_i,
    input  logic             wr_en_i,
    input  logic [2:0]       wr_addr_i,
    input  logic [FTW_W-1:0] wr_data_i,
    input  logic             upd_i,
    output logic [PH_W-1:0]  phase_o,
    output logic [AMP_W-1:0] sample_o
);
    import dds_pkg::*;

    localparam int PROD_W = 2 * AMP_W + 1;

    logic [FTW_W-1:0]         inc_a, inc_b, inc_used, acc_q;
    logic [POW_W-1:0]         ofs_a, ofs_b, ofs_used;
    logic [AMP_W-1:0]         amp_q;
    logic [2:0]               mode_q;
    logic                     upd_pulse;
    logic signed [AMP_W-1:0]  cos_q;
    logic signed [PROD_W-1:0] prod;

    dds_cfg_bank #(
        .FTW_W(FTW_W), .POW_W(POW_W), .AMP_W(AMP_W), .SYNC_N(SYNC_N)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i), .upd_i(upd_i), .inc_a_o(inc_a), .inc_b_o(inc_b),
        .ofs_a_o(ofs_a), .ofs_b_o(ofs_b), .amp_o(amp_q), .mode_o(mode_q),
        .upd_pulse_o(upd_pulse)
    );

    // Mode decode: only FSK and BPSK let the select pin switch a register pair.
    always_comb begin
        inc_used = (mode_q == MD_FSK  && sel_i) ? inc_b : inc_a;
        ofs_used = (mode_q == MD_BPSK && sel_i) ? ofs_b : ofs_a;
    end

    dds_phase_path #(
        .FTW_W(FTW_W), .POW_W(POW_W), .PH_W(PH_W)
    ) path_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(inc_used),
        .ofs_i(ofs_used), .acc_o(acc_q), .phase_o(phase_o)
    );

    dds_cos_lut #(
        .PH_W(PH_W), .LUT_AW(LUT_AW), .AMP_W(AMP_W)
    ) lut_i (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_o), .cos_o(cos_q)
    );

    // Signed sample times unsigned amplitude, full width.
    always_comb begin
        prod = PROD_W'(cos_q) * $signed({{(AMP_W + 1){1'b0}}, amp_q});
    end

    // Register the scaled sample (floor division by 2^AMP_W).
    always_ff @(posedge clk) begin
        if (!rst_n) sample_o <= '0;
        else        sample_o <= AMP_W'(prod >>> AMP_W);
    end
endmodule

// File: rtl/dds_core_chk.sv
// Module dds_core_chk
// Property checker for dds_core, attached to it by bind. It watches the
// working registers, the accumulator, the selected register pair and the
// outputs.
// Assumes synchronous active-low reset.
module dds_core_chk #(
    parameter int FTW_W = 48,
    parameter int POW_W = 14,
    parameter int PH_W  = 17,
    parameter int AMP_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             upd_pulse,
    input logic [2:0]       mode_q,
    input logic [FTW_W-1:0] inc_a,
    input logic [FTW_W-1:0] inc_b,
    input logic [FTW_W-1:0] inc_used,
    input logic [FTW_W-1:0] acc_q,
    input logic [POW_W-1:0] ofs_a,
    input logic [POW_W-1:0] ofs_b,
    input logic [POW_W-1:0] ofs_used,
    input logic [AMP_W-1:0] amp_q,
    input logic [PH_W-1:0]  phase_o,
    input logic [AMP_W-1:0] sample_o
);
    localparam int OFS_SH = PH_W - POW_W;

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_pulse |=> ($stable(inc_a) && $stable(inc_b) && $stable(ofs_a) && $stable(ofs_b) && $stable(amp_q) && $stable(mode_q))); // R3

    AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (acc_q == '0)); // R4

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (acc_q == FTW_W'($past(acc_q) + $past(inc_used)))); // R4

    AST_PHASE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_o == PH_W'($past(acc_q[FTW_W-1 -: PH_W]) + (PH_W'($past(ofs_used)) << OFS_SH)))); // R5

    AST_TONE_PAIR_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != 3'b001 && mode_q != 3'b100) |-> (inc_used == inc_a && ofs_used == ofs_a)); // R6

    AST_ZERO_AMP: assert property (@(posedge clk) disable iff (!rst_n)
        (amp_q == '0) |=> (sample_o == '0)); // R8
endmodule

bind dds_core dds_core_chk #(
    .FTW_W(FTW_W), .POW_W(POW_W), .PH_W(PH_W), .AMP_W(AMP_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .upd_pulse(upd_pulse),
    .mode_q(mode_q), .inc_a(inc_a), .inc_b(inc_b), .inc_used(inc_used),
    .acc_q(acc_q), .ofs_a(ofs_a), .ofs_b(ofs_b), .ofs_used(ofs_used),
    .amp_q(amp_q), .phase_o(phase_o), .sample_o(sample_o)
);

// File: tb/dds_core_tb_top.sv
// Bench dds_core_tb_top
// Directed scenarios for dds_core. Each task drives one scenario and checks
// its own results. Inputs change on the falling edge; outputs are sampled there.
module dds_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_i = 1'b1;
    logic        sel_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_addr_i = 3'd0;
    logic [47:0] wr_data_i = 48'd0;
    logic        upd_i = 1'b0;
    logic [16:0] phase_o;
    logic [11:0] sample_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dds_core dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .sel_i(sel_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .upd_i(upd_i), .phase_o(phase_o), .sample_o(sample_o)
    );

    // Print the single summary line.
    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // Exact comparison.
    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Comparison within 1 LSB.
    task automatic chk_tol(input string req, input longint act, input longint exp);
        checks++;
        if (act > exp + 1 || act < exp - 1) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Write one buffer field.
    task automatic wr(input logic [2:0] a, input logic [47:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Pulse the update strobe and wait past the synchroniser.
    task automatic update();
        @(negedge clk); upd_i = 1'b1;
        @(negedge clk); upd_i = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    // Start a ramp from zero and check six phase words.
    task automatic ramp(input string req, input longint inc, input longint ofs);
        clr_i = 1'b1;
        repeat (2) @(negedge clk);
        clr_i = 1'b0;
        for (int m = 1; m <= 6; m++) begin
            longint a, exp;
            @(negedge clk);
            a   = (longint'(m - 1) * inc) & 64'hFFFF_FFFF_FFFF;
            exp = ((a >> 31) + ofs * 8) & 64'h1FFFF;
            chk(req, phase_o, exp);
        end
        clr_i = 1'b1;
    endtask

    // Expected scaled cosine for a phase word.
    function automatic longint exp_sample(input longint ph, input longint amp);
        longint b, c;
        real x;
        b = ph >> 10;
        x = 2047.0 * $cos(2.0 * 3.14159265358979 * (real'(b) + 0.5) / 128.0);
        c = longint'($floor(x + 0.5));
        return (c * amp) >>> 12;
    endfunction

    // Free-running sweep: each sample must match the phase word two cycles back.
    task automatic cos_run(input string req, input longint amp, input int n);
        longint p1, p2;
        clr_i = 1'b0;
        @(negedge clk); p2 = phase_o;
        @(negedge clk); p1 = phase_o;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk_tol(req, longint'($signed(sample_o)), exp_sample(p2, amp));
            p2 = p1; p1 = phase_o;
        end
        clr_i = 1'b1;
    endtask

    task automatic t_reset();
        chk("R1 phase", phase_o, 0);
        chk("R1 sample", sample_o, 0);
    endtask

    // R2: a pending increment must not move the phase before an update.
    task automatic t_buffer();
        wr(3'd0, 48'h0100_0000_0000);
        wr(3'd4, 48'd4095);
        clr_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 phase before update", phase_o, 0);
        chk("R2 sample before update", sample_o, 0);
        clr_i = 1'b1;
        update();
        ramp("R2 R4 ramp after update", 64'h0100_0000_0000, 0);
    endtask

    task automatic t_wrap();
        wr(3'd0, 48'h8000_0000_0000);
        update();
        ramp("R4 wrap", 64'h8000_0000_0000, 0);
    endtask

    // R3: increment and offset written together, applied by one update.
    task automatic t_atomic();
        wr(3'd0, 48'h0100_0000_0000);
        wr(3'd2, 48'h3FFF);
        repeat (3) @(negedge clk);
        chk("R3 offset pending", phase_o, 0);
        update();
        chk("R3 R5 offset applied on clear", phase_o, 17'h1FFF8);
        ramp("R3 R5 offset wrap ramp", 64'h0100_0000_0000, 64'h3FFF);
    endtask

    task automatic t_modes();
        wr(3'd2, 48'd0);
        wr(3'd1, 48'h0200_0000_0000);
        wr(3'd3, 48'd100);
        wr(3'd5, 48'd1);
        update();
        sel_i = 1'b1; ramp("R6 fsk sel1", 64'h0200_0000_0000, 0);
        sel_i = 1'b0; ramp("R6 fsk sel0", 64'h0100_0000_0000, 0);
        wr(3'd5, 48'd0); update();
        sel_i = 1'b1; ramp("R6 tone ignores sel", 64'h0100_0000_0000, 0);
        wr(3'd5, 48'd2); update();
        ramp("R6 mode010 as tone", 64'h0100_0000_0000, 0);
        wr(3'd5, 48'd7); update();
        ramp("R6 mode111 as tone", 64'h0100_0000_0000, 0);
        wr(3'd5, 48'd4); update();
        sel_i = 1'b1; ramp("R6 bpsk sel1", 64'h0100_0000_0000, 100);
        sel_i = 1'b0; ramp("R6 bpsk sel0", 64'h0100_0000_0000, 0);
        wr(3'd5, 48'd0); update();
    endtask

    task automatic t_cosine();
        wr(3'd0, 48'h0123_4567_89AB);
        wr(3'd4, 48'd4095);
        update();
        cos_run("R7 R8 full scale", 4095, 80);
        wr(3'd4, 48'd1000); update();
        cos_run("R8 scale 1000", 1000, 40);
        wr(3'd4, 48'd0); update();
        clr_i = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 zero amplitude", sample_o, 0);
        clr_i = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_buffer();
        t_wrap();
        t_atomic();
        t_modes();
        t_cosine();
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1000000;
        checks++; errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        summary();
        $finish;
    end
endmodule